// File: doc/BRIEF.md
# Effective Address Generator

This block produces the 24-bit effective address for byte loads and stores in a small 24-bit processor datapath. Each request carries several operands: an address-register value, a data-register value used as an index, the low 16 bits of the instruction word, an 8-bit extension byte and a decoded 3-bit addressing-mode code. From these the block forms one address.

Seven modes are supported:
- plain register indirect;
- register plus a sign-extended 8-bit displacement;
- register plus a sign-extended 16-bit displacement;
- register plus a full 24-bit displacement built from the instruction half-word and the extension byte;
- register plus index register;
- a zero-extended 16-bit absolute address;
- a 24-bit absolute address.

The result is registered. It appears one clock after the request is sampled, with a valid strobe. All sums wrap modulo 2^24.

Top module: `eag_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with no request, `ea_valid` is 0 and `ea_addr` is 0.
- R2: A request sampled on a rising edge with `req_valid`=1 and a legal mode gives `ea_valid`=1 after that edge. A cycle with `req_valid`=0 gives `ea_valid`=0 and `ea_addr`=0 after the next edge.
- R3: Mode 0 (indirect): `ea_addr` equals `a_val`.
- R4: Mode 1: `ea_addr` = `a_val` + `instr_lo[7:0]` sign-extended to 24 bits.
- R5: Mode 2: `ea_addr` = `a_val` + `instr_lo` sign-extended to 24 bits.
- R6: Mode 3: `ea_addr` = `a_val` + {`instr_lo`, `ext_byte`}, where `instr_lo` forms bits 23:8 and `ext_byte` forms bits 7:0.
- R7: Mode 4 (indexed): `ea_addr` = `a_val` + `d_val`.
- R8: Mode 5: `ea_addr` = `instr_lo` zero-extended, with `a_val` and `d_val` having no effect.
- R9: Mode 6: `ea_addr` = {`instr_lo`, `ext_byte`}, with `a_val` and `d_val` having no effect.
- R10: Mode 7 is unused. A request with it gives `ea_valid`=0 and `ea_addr`=0.
- R11: Every sum is truncated to 24 bits, so a carry out of bit 23 is dropped. For example, 0xFFFFFF + 1 = 0x000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request qualifier |
| mode | input | 3 | Addressing-mode code (0..6 legal) |
| a_val | input | 24 | Address-register value |
| d_val | input | 24 | Index (data-register) value |
| instr_lo | input | 16 | Low half-word of the instruction |
| ext_byte | input | 8 | Instruction extension byte |
| ea_addr | output | 24 | Registered effective address |
| ea_valid | output | 1 | Registered valid strobe |

## Verification
On every cycle the in-module properties check the following:
- a legal request raises the strobe one edge later;
- the unused code and idle cycles leave the strobe low;
- the address is zero whenever the strobe is low;
- the indirect and both absolute modes return exactly the operand they name.

The displacement arithmetic needs the bench's scenarios to show it. This covers the sign extension of negative 8-bit and 16-bit fields, the ordering of the half-word and extension byte in the 24-bit forms, the indexed sum, and wrap-around past 0xFFFFFF. The bench's model checks these with chosen and random operands.

// File: rtl/eag_pkg.sv
package eag_pkg;
   typedef enum logic [2:0] {
      EA_IND   = 3'd0,
      EA_D8    = 3'd1,
      EA_D16   = 3'd2,
      EA_D24   = 3'd3,
      EA_IDX   = 3'd4,
      EA_ABS16 = 3'd5,
      EA_ABS24 = 3'd6,
      EA_RSVD  = 3'd7
   } ea_mode_e;
endpackage

// File: rtl/eag_operand_sel.sv
module eag_operand_sel #(
   parameter int AW  = 24,
   parameter int IW  = 16,
   parameter int EW  = 8,
   parameter int SW  = 8
) (
   input  logic [2:0]    mode,
   input  logic [AW-1:0] a_val,
   input  logic [AW-1:0] d_val,
   input  logic [IW-1:0] instr_lo,
   input  logic [EW-1:0] ext_byte,
   output logic [AW-1:0] base,
   output logic [AW-1:0] offset,
   output logic          legal
);
   import eag_pkg::*;

   localparam int PAD_S = AW - SW;
   localparam int PAD_I = AW - IW;

   logic [AW-1:0] sx_short, sx_half, zx_half, wide;

   generate
      if (PAD_S > 0) begin : g_sx_short
         assign sx_short = {{PAD_S{instr_lo[SW-1]}}, instr_lo[SW-1:0]};
      end else begin : g_sx_short_full
         assign sx_short = instr_lo[AW-1:0];
      end
      if (PAD_I > 0) begin : g_half
         assign sx_half = {{PAD_I{instr_lo[IW-1]}}, instr_lo};
         assign zx_half = {{PAD_I{1'b0}}, instr_lo};
      end else begin : g_half_full
         assign sx_half = instr_lo[AW-1:0];
         assign zx_half = instr_lo[AW-1:0];
      end
   endgenerate

   assign wide = {instr_lo, ext_byte};

   always_comb begin
      base   = '0;
      offset = '0;
      legal  = 1'b1;
      unique case (ea_mode_e'(mode))
         EA_IND:   base = a_val;
         EA_D8:    begin base = a_val; offset = sx_short; end
         EA_D16:   begin base = a_val; offset = sx_half;  end
         EA_D24:   begin base = a_val; offset = wide;     end
         EA_IDX:   begin base = a_val; offset = d_val;    end
         EA_ABS16: offset = zx_half;
         EA_ABS24: offset = wide;
         default:  legal = 1'b0;
      endcase
   end
endmodule

// File: rtl/eag_adder.sv
module eag_adder #(
   parameter int AW = 24
) (
   input  logic [AW-1:0] x,
   input  logic [AW-1:0] y,
   output logic [AW-1:0] sum
);
   logic [AW:0] full;
   assign full = {1'b0, x} + {1'b0, y};
   // R11: carry out of the top bit is discarded
   assign sum  = full[AW-1:0];
endmodule

// File: rtl/eag_top.sv
module eag_top #(
   parameter int AW = 24,
   parameter int IW = 16,
   parameter int EW = 8,
   parameter int SW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [2:0]    mode,
   input  logic [AW-1:0] a_val,
   input  logic [AW-1:0] d_val,
   input  logic [IW-1:0] instr_lo,
   input  logic [EW-1:0] ext_byte,
   output logic [AW-1:0] ea_addr,
   output logic          ea_valid
);
   import eag_pkg::*;

   generate
      if (AW != IW + EW) begin : g_bad_width
         $error("eag_top: AW must equal IW + EW");
      end
      if (SW > IW || SW < 1) begin : g_bad_short
         $error("eag_top: SW must lie in 1..IW");
      end
   endgenerate

   logic [AW-1:0] base, offset, sum;
   logic          legal;

   eag_operand_sel #(.AW(AW), .IW(IW), .EW(EW), .SW(SW)) u_sel (
      .mode(mode), .a_val(a_val), .d_val(d_val),
      .instr_lo(instr_lo), .ext_byte(ext_byte),
      .base(base), .offset(offset), .legal(legal)
   );

   eag_adder #(.AW(AW)) u_add (.x(base), .y(offset), .sum(sum));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea_addr  <= '0;
         ea_valid <= 1'b0;
      end else if (req_valid && legal) begin
         ea_addr  <= sum;
         ea_valid <= 1'b1;
      end else begin
         ea_addr  <= '0;
         ea_valid <= 1'b0;
      end
   end

   // R2
   strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode != 3'd7) |=> ea_valid);
   // R10
   rsvd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid || mode == 3'd7) |=> !ea_valid);
   // R10
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ea_valid |-> ea_addr == '0);
   // R3
   indirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode == 3'd0) |=> ea_addr == $past(a_val));
   // R8
   abs_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode == 3'd5) |=> ea_addr == AW'($past(instr_lo)));
   // R9
   abs_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode == 3'd6) |=> ea_addr == {$past(instr_lo), $past(ext_byte)});
endmodule

// File: tb/sim_eag_top.sv
module sim_eag_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  mode = '0;
   logic [23:0] a_val = '0, d_val = '0;
   logic [15:0] instr_lo = '0;
   logic [7:0]  ext_byte = '0;
   logic [23:0] ea_addr;
   logic        ea_valid;

   int errors = 0, checks = 0;
   bit done = 0;
   bit have_exp = 0;
   logic [23:0] exp_addr;
   logic        exp_valid;
   string       exp_req;

   always #5 clk = ~clk;

   eag_top u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
               .a_val(a_val), .d_val(d_val), .instr_lo(instr_lo),
               .ext_byte(ext_byte), .ea_addr(ea_addr), .ea_valid(ea_valid));

   task automatic check(string req, logic [23:0] act_a, logic act_v,
                        logic [23:0] ex_a, logic ex_v);
      checks++;
      if (act_a !== ex_a || act_v !== ex_v) begin
         errors++;
         $display("FAIL %s: addr=%h valid=%b expected addr=%h valid=%b",
                  req, act_a, act_v, ex_a, ex_v);
      end
   endtask

   function automatic string tag_of(bit v, int m, bit wrap);
      if (!v) return "R2";
      if (wrap) return "R11";
      case (m)
         0: return "R3";
         1: return "R4";
         2: return "R5";
         3: return "R6";
         4: return "R7";
         5: return "R8";
         6: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic apply(bit v, int m, int a, int d, int iw, int ex, bit wrap = 0);
      longint total;
      longint off;
      @(negedge clk);
      if (have_exp) check(exp_req, ea_addr, ea_valid, exp_addr, exp_valid);
      req_valid = v; mode = 3'(m); a_val = 24'(a); d_val = 24'(d);
      instr_lo = 16'(iw); ext_byte = 8'(ex);
      total = 0;
      case (m)
         0: total = a;
         1: begin off = (iw & 'hFF); if (off >= 128) off -= 256; total = a + off; end
         2: begin off = (iw & 'hFFFF); if (off >= 32768) off -= 65536; total = a + off; end
         3: total = a + (iw & 'hFFFF) * 256 + (ex & 'hFF);
         4: total = a + d;
         5: total = iw & 'hFFFF;
         6: total = (iw & 'hFFFF) * 256 + (ex & 'hFF);
         default: total = 0;
      endcase
      exp_valid = v && (m != 7);
      exp_addr  = exp_valid ? 24'(total & 'hFFFFFF) : 24'h0;
      exp_req   = (v && m == 7) ? "R10" : tag_of(v, m, wrap);
      have_exp  = 1;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", ea_addr, ea_valid, 24'h0, 1'b0);   // R1 during reset
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", ea_addr, ea_valid, 24'h0, 1'b0);   // R1 after release, idle
      apply(1, 0, 'h123456, 'h0, 'hFFFF, 'hFF);       // R3
      apply(1, 1, 'h001000, 0, 'h0080, 0);            // R4 negative -128
      apply(1, 1, 'h001000, 0, 'hAA7F, 0);            // R4 +127, upper bits ignored
      apply(1, 2, 'h010000, 0, 'h8000, 0);            // R5 negative
      apply(1, 2, 'h000010, 0, 'h7FF0, 0);            // R5 positive
      apply(1, 3, 'h000001, 0, 'h1234, 'h56);         // R6 ordering
      apply(1, 4, 'h100000, 'h0ABCDE, 0, 0);          // R7
      apply(1, 5, 'hFFFFFF, 'hFFFFFF, 'h8001, 'hFF);  // R8 zero-extend, regs ignored
      apply(1, 6, 'hFFFFFF, 'hFFFFFF, 'hABCD, 'hEF);  // R9 regs ignored
      apply(1, 7, 'h123456, 'h111111, 'h2222, 'h33);  // R10
      apply(0, 4, 'h123456, 'h111111, 0, 0);          // R2 idle
      apply(1, 1, 'hFFFFFF, 0, 'h0001, 0, 1);         // R11 wrap to 0
      apply(1, 4, 'hF00000, 'h200000, 0, 0, 1);       // R11 wrap
      apply(1, 3, 'hFFFF00, 0, 'h0001, 'h10, 1);      // R11 wrap
      for (int i = 0; i < 400; i++)
         apply(($urandom % 8) != 0, int'($urandom % 8), int'($urandom & 'hFFFFFF),
               int'($urandom & 'hFFFFFF), int'($urandom & 'hFFFF), int'($urandom & 'hFF));
      apply(0, 0, 0, 0, 0, 0);
      apply(0, 0, 0, 0, 0, 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule